// File: doc/BRIEF.md
# Serial Permuting Block Mover

This engine copies one block of K words from a source data memory to a destination data memory and reorders the words on the way. It moves one word per clock. The engine has no storage of its own. It drives the read ports of a source memory and an address-table memory, and the write port of a destination memory. All three memories are synchronous and register their address, so read data arrives in the cycle after the address is presented.

There are two movement modes:

- **Permute-on-read:** the permuted address selects the source word, and the destination is filled in order.
- **Permute-on-write:** the source is read in order, and the permuted address places each word in the destination.

The permuted address comes from one of two sources. The first is the table memory, read at sequential addresses; in permute-on-write it holds the inverse map. The second is an internal generator for the quadratic map P(i) = (f1·i + f2·i²) mod K. The generator updates its value with two modular additions per step and uses no multiplier.

A one-cycle start pulse samples all settings: mode, address source, K, f1 and f2. These settings then stay fixed until the block is finished. A one-cycle done pulse marks the end of the block.

Top module: `ilv_engine`

## Requirements
- R1: When `perm_on_wr`=0, the word written in the i-th write cycle (i = 0 … K−1) goes to destination address i and carries source word P(i).
- R2: When `perm_on_wr`=1, the word written in the i-th write cycle goes to destination address P(i) and carries source word i. The source is read at addresses 0, 1, …, K−1 in order.
- R3: When `addr_gen`=0, P(i) is the table word at address i. The table is read once per issue cycle at addresses 0, 1, …, K−1 in order.
- R4: When `addr_gen`=1, P(i) = (f1·i + f2·i²) mod K for any K from 40 to 6144 and any f1, f2 < K. The table port stays idle (`tbl_rd_en`=0) for the whole block.
- R5: After a start is accepted at a clock edge, `dst_wr_en` first goes high in the third cycle after that edge. It then stays high for exactly K consecutive cycles, one word per cycle.
- R6: `done` is a single-cycle pulse in the cycle after the last write cycle, which is the (K+3)-th cycle after the start edge. `busy` is high from the cycle after the start edge until `done` rises, and is low while `done` is high.
- R7: While `busy` is high, `start` is ignored, and changes on `perm_on_wr`, `addr_gen`, `blk_len`, `coef_lin` and `coef_sq` do not affect the block in progress.
- R8: After reset, `busy`, `done`, `tbl_rd_en`, `src_rd_en` and `dst_wr_en` are all low. No memory access happens while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, accepted only while idle |
| perm_on_wr | input | 1 | 0 = permute on read, 1 = permute on write |
| addr_gen | input | 1 | 0 = table memory, 1 = quadratic generator |
| blk_len | input | ADDR_W | Block length K |
| coef_lin | input | ADDR_W | Linear coefficient f1 (< K) |
| coef_sq | input | ADDR_W | Quadratic coefficient f2 (< K) |
| busy | output | 1 | Block in progress |
| done | output | 1 | One-cycle end-of-block pulse |
| tbl_rd_en | output | 1 | Table read enable |
| tbl_addr | output | ADDR_W | Table read address |
| tbl_data | input | ADDR_W | Table read data (one cycle after address) |
| src_rd_en | output | 1 | Source read enable |
| src_addr | output | ADDR_W | Source read address |
| src_data | input | DATA_W | Source read data (one cycle after address) |
| dst_wr_en | output | 1 | Destination write enable |
| dst_addr | output | ADDR_W | Destination write address |
| dst_data | output | DATA_W | Destination write data |

## Verification
The hardest situation to reach from the ports is a settings change, or a fresh start pulse, that arrives in the middle of a block while the three-stage pipeline is full. A wrong design would then mix two configurations across items that are already in flight. The bench raises `start` mid-block and at the same time flips the mode, the address source and the length. It then requires every later write to match the original settings and requires `done` to arrive at the original cycle count.

A second hard case is generator wrap-around at large K. This is reached with a 1008-word block, where the incremental sums cross K many times. Each write is compared against the quadratic formula, which the bench evaluates directly with full multiplications.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

  // Movement mode: which side of the copy is permuted
  typedef enum logic {
    MV_PERM_RD = 1'b0,
    MV_PERM_WR = 1'b1
  } mv_mode_e;

  // Origin of the permuted address
  typedef enum logic {
    AS_TABLE = 1'b0,
    AS_QPP   = 1'b1
  } addr_src_e;

  // Registers between issue and write: table/generator, source, destination
  localparam int unsigned PIPE_STAGES = 3;

endpackage

// File: rtl/ilv_qpp_gen.sv
module ilv_qpp_gen #(
  parameter int unsigned ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init,
  input  logic              step,
  input  logic [ADDR_W-1:0] k_in,
  input  logic [ADDR_W-1:0] k_run,
  input  logic [ADDR_W-1:0] f1,
  input  logic [ADDR_W-1:0] f2,
  output logic [ADDR_W-1:0] pi
);

  // (a + b) mod k for a, b < k
  function automatic logic [ADDR_W-1:0] mod_add(
    input logic [ADDR_W-1:0] a,
    input logic [ADDR_W-1:0] b,
    input logic [ADDR_W-1:0] k
  );
    logic [ADDR_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    if (s >= {1'b0, k}) s = s - {1'b0, k};
    return s[ADDR_W-1:0];
  endfunction

  logic [ADDR_W-1:0] pi_q, gap_q, dgap_q;

  // pi holds P(i); gap holds P(i+1)-P(i); dgap is the constant 2*f2 mod K
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pi_q   <= '0;
      gap_q  <= '0;
      dgap_q <= '0;
    end else if (init) begin
      pi_q   <= '0;
      gap_q  <= mod_add(f1, f2, k_in);
      dgap_q <= mod_add(f2, f2, k_in);
    end else if (step) begin
      pi_q  <= mod_add(pi_q, gap_q, k_run);
      gap_q <= mod_add(gap_q, dgap_q, k_run);
    end
  end

  assign pi = pi_q;

endmodule

// File: rtl/ilv_seq_ctrl.sv
module ilv_seq_ctrl
  import ilv_pkg::*;
#(
  parameter int unsigned ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              mode_in,
  input  logic              src_in,
  input  logic [ADDR_W-1:0] k_in,
  input  logic              fin,
  output logic              accept,
  output logic              busy,
  output logic              done,
  output logic              issuing,
  output logic              last_issue,
  output logic [ADDR_W-1:0] idx,
  output mv_mode_e          mode_q,
  output addr_src_e         src_q,
  output logic [ADDR_W-1:0] k_q
);

  logic busy_q, done_q, iss_q;
  logic [ADDR_W-1:0] idx_q;

  assign accept     = start && !busy_q;
  assign last_issue = iss_q && (idx_q == k_q - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      iss_q  <= 1'b0;
      idx_q  <= '0;
      mode_q <= MV_PERM_RD;
      src_q  <= AS_TABLE;
      k_q    <= '0;
    end else begin
      done_q <= fin;
      if (accept) begin
        busy_q <= 1'b1;
        iss_q  <= 1'b1;
        idx_q  <= '0;
        mode_q <= mv_mode_e'(mode_in);
        src_q  <= addr_src_e'(src_in);
        k_q    <= k_in;
      end else begin
        if (fin) busy_q <= 1'b0;
        if (iss_q) begin
          idx_q <= idx_q + 1'b1;
          if (last_issue) iss_q <= 1'b0;
        end
      end
    end
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign issuing = iss_q;
  assign idx     = idx_q;

endmodule

// File: rtl/ilv_datapath.sv
module ilv_datapath
  import ilv_pkg::*;
#(
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              v0,
  input  logic              last0,
  input  logic [ADDR_W-1:0] idx,
  input  logic [ADDR_W-1:0] pi,
  input  mv_mode_e          mode_q,
  input  addr_src_e         src_q,
  input  logic [ADDR_W-1:0] tbl_data,
  input  logic [DATA_W-1:0] src_data,
  output logic              tbl_rd_en,
  output logic [ADDR_W-1:0] tbl_addr,
  output logic              src_rd_en,
  output logic [ADDR_W-1:0] src_addr,
  output logic              dst_wr_en,
  output logic [ADDR_W-1:0] dst_addr,
  output logic [DATA_W-1:0] dst_data,
  output logic [ADDR_W-1:0] perm_s1,
  output logic              fin
);

  // stage 1: table data / generator value arrive
  logic              v1, last1;
  logic [ADDR_W-1:0] seq1, gen1;
  // stage 2: source data arrives
  logic              v2, last2;
  logic [ADDR_W-1:0] seq2, perm2;

  assign tbl_rd_en = v0 && (src_q == AS_TABLE);
  assign tbl_addr  = idx;

  assign perm_s1   = (src_q == AS_QPP) ? gen1 : tbl_data;
  assign src_rd_en = v1;
  assign src_addr  = (mode_q == MV_PERM_RD) ? perm_s1 : seq1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1    <= 1'b0;
      last1 <= 1'b0;
      seq1  <= '0;
      gen1  <= '0;
      v2    <= 1'b0;
      last2 <= 1'b0;
      seq2  <= '0;
      perm2 <= '0;
    end else begin
      v1    <= v0;
      last1 <= last0;
      v2    <= v1;
      last2 <= last1;
      if (v0) begin
        seq1 <= idx;
        gen1 <= pi;
      end
      if (v1) begin
        seq2  <= seq1;
        perm2 <= perm_s1;
      end
    end
  end

  assign dst_wr_en = v2;
  assign dst_addr  = (mode_q == MV_PERM_RD) ? seq2 : perm2;
  assign dst_data  = src_data;
  assign fin       = v2 && last2;

endmodule

// File: rtl/ilv_engine.sv
module ilv_engine
  import ilv_pkg::*;
#(
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned DATA_W = 16,
  parameter bit          QPP_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              perm_on_wr,
  input  logic              addr_gen,
  input  logic [ADDR_W-1:0] blk_len,
  input  logic [ADDR_W-1:0] coef_lin,
  input  logic [ADDR_W-1:0] coef_sq,
  output logic              busy,
  output logic              done,
  output logic              tbl_rd_en,
  output logic [ADDR_W-1:0] tbl_addr,
  input  logic [ADDR_W-1:0] tbl_data,
  output logic              src_rd_en,
  output logic [ADDR_W-1:0] src_addr,
  input  logic [DATA_W-1:0] src_data,
  output logic              dst_wr_en,
  output logic [ADDR_W-1:0] dst_addr,
  output logic [DATA_W-1:0] dst_data
);

  // named internal events, visible to the bound checker
  logic              start_ok;
  logic              issuing;
  logic              last_issue;
  logic              fin;
  logic [ADDR_W-1:0] idx;
  logic [ADDR_W-1:0] gen_pi;
  logic [ADDR_W-1:0] perm_s1;
  logic [ADDR_W-1:0] cfg_k;
  mv_mode_e          cfg_mode;
  addr_src_e         cfg_src;

  ilv_seq_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .mode_in    (perm_on_wr),
    .src_in     (addr_gen),
    .k_in       (blk_len),
    .fin        (fin),
    .accept     (start_ok),
    .busy       (busy),
    .done       (done),
    .issuing    (issuing),
    .last_issue (last_issue),
    .idx        (idx),
    .mode_q     (cfg_mode),
    .src_q      (cfg_src),
    .k_q        (cfg_k)
  );

  generate
    if (QPP_EN) begin : g_qpp
      ilv_qpp_gen #(.ADDR_W(ADDR_W)) u_gen (
        .clk   (clk),
        .rst_n (rst_n),
        .init  (start_ok),
        .step  (issuing),
        .k_in  (blk_len),
        .k_run (cfg_k),
        .f1    (coef_lin),
        .f2    (coef_sq),
        .pi    (gen_pi)
      );
    end else begin : g_no_qpp
      logic unused_ok;
      assign unused_ok = ^{coef_lin, coef_sq};
      assign gen_pi    = '0;
    end
  endgenerate

  ilv_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .v0        (issuing),
    .last0     (last_issue),
    .idx       (idx),
    .pi        (gen_pi),
    .mode_q    (cfg_mode),
    .src_q     (cfg_src),
    .tbl_data  (tbl_data),
    .src_data  (src_data),
    .tbl_rd_en (tbl_rd_en),
    .tbl_addr  (tbl_addr),
    .src_rd_en (src_rd_en),
    .src_addr  (src_addr),
    .dst_wr_en (dst_wr_en),
    .dst_addr  (dst_addr),
    .dst_data  (dst_data),
    .perm_s1   (perm_s1),
    .fin       (fin)
  );

endmodule

// File: rtl/ilv_engine_chk.sv
module ilv_engine_chk #(
  parameter int unsigned ADDR_W = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              tbl_rd_en,
  input logic              src_rd_en,
  input logic              dst_wr_en,
  input logic [ADDR_W-1:0] dst_addr,
  input logic [ADDR_W-1:0] perm_s1,
  input logic [ADDR_W-1:0] cfg_k,
  input logic              cfg_mode,
  input logic              cfg_src
);

  AST_WR_AFTER_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    dst_wr_en |-> $past(src_rd_en)); // R5

  AST_SRC_AFTER_TBL: assert property (@(posedge clk) disable iff (!rst_n)
    (src_rd_en && !cfg_src) |-> $past(tbl_rd_en)); // R3

  AST_QPP_TBL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cfg_src) |-> !tbl_rd_en); // R4

  AST_GEN_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (src_rd_en && cfg_src) |-> (perm_s1 < cfg_k)); // R4

  AST_DST_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    dst_wr_en |-> (dst_addr < cfg_k)); // R1

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(dst_wr_en) && !dst_wr_en && !busy)); // R6

  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(cfg_mode) && $stable(cfg_src) && $stable(cfg_k))); // R7

  AST_IDLE_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!tbl_rd_en && !src_rd_en && !dst_wr_en)); // R8

endmodule

bind ilv_engine ilv_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .done      (done),
  .tbl_rd_en (tbl_rd_en),
  .src_rd_en (src_rd_en),
  .dst_wr_en (dst_wr_en),
  .dst_addr  (dst_addr),
  .perm_s1   (perm_s1),
  .cfg_k     (cfg_k),
  .cfg_mode  (cfg_mode),
  .cfg_src   (cfg_src)
);

// File: tb/test_ilv_engine.sv
module test_ilv_engine;

  localparam int AW = 13;
  localparam int DW = 16;
  localparam int MEMD = 1024;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          perm_on_wr = 1'b0;
  logic          addr_gen = 1'b0;
  logic [AW-1:0] blk_len = '0;
  logic [AW-1:0] coef_lin = '0;
  logic [AW-1:0] coef_sq = '0;
  logic          busy, done;
  logic          tbl_rd_en, src_rd_en, dst_wr_en;
  logic [AW-1:0] tbl_addr, src_addr, dst_addr;
  logic [AW-1:0] tbl_q = '0;
  logic [DW-1:0] src_q = '0;
  logic [DW-1:0] dst_data;

  logic [AW-1:0] tbl_mem [MEMD];
  logic [DW-1:0] src_mem [MEMD];

  int total = 0;
  int bad = 0;
  string cur_req = "R1";

  int exp_addr [$];
  int exp_data [$];

  always #2.5 clk = ~clk;

  ilv_engine #(.ADDR_W(AW), .DATA_W(DW)) i_ilv_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .perm_on_wr(perm_on_wr),
    .addr_gen(addr_gen), .blk_len(blk_len), .coef_lin(coef_lin), .coef_sq(coef_sq),
    .busy(busy), .done(done),
    .tbl_rd_en(tbl_rd_en), .tbl_addr(tbl_addr), .tbl_data(tbl_q),
    .src_rd_en(src_rd_en), .src_addr(src_addr), .src_data(src_q),
    .dst_wr_en(dst_wr_en), .dst_addr(dst_addr), .dst_data(dst_data)
  );

  // synchronous memories with registered address
  always @(posedge clk) begin
    if (tbl_rd_en) tbl_q <= tbl_mem[tbl_addr % MEMD];
    if (src_rd_en) src_q <= src_mem[src_addr % MEMD];
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // monitor: pops the scoreboard on every write cycle
  always @(negedge clk) begin
    if (rst_n && dst_wr_en) begin
      if (exp_addr.size() == 0) begin
        chk(1'b0, "R5", "unexpected write", 1, 0);
      end else begin
        int ea, ed;
        ea = exp_addr.pop_front();
        ed = exp_data.pop_front();
        chk(int'(dst_addr) == ea, cur_req, "dst_addr", dst_addr, ea);
        chk(int'(dst_data) == ed, cur_req, "dst_data", dst_data, ed);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "WD", "watchdog expired", 0, 1);
    summary();
  end

  function automatic int perm_of(input bit qp, input int i, input int k,
                                 input int f1, input int f2);
    longint v;
    if (qp) begin
      v = (longint'(f1) * i + longint'(f2) * i * i) % k;
      return int'(v);
    end
    return int'(tbl_mem[i]);
  endfunction

  task automatic run_block(input bit md, input bit qp, input int k,
                           input int f1, input int f2, input bit perturb,
                           input int seed, input string req);
    int first_wr, done_cyc, tcnt, tbl_bad;
    for (int i = 0; i < MEMD; i++) begin
      src_mem[i] = DW'((i * 97 + seed * 31 + 5) ^ (i << 3));
      tbl_mem[i] = AW'((13 * i + 5) % k);
    end
    for (int i = 0; i < k; i++) begin
      int p;
      p = perm_of(qp, i, k, f1, f2);
      if (!md) begin
        exp_addr.push_back(i);
        exp_data.push_back(int'(src_mem[p]));
      end else begin
        exp_addr.push_back(p);
        exp_data.push_back(int'(src_mem[i]));
      end
    end
    cur_req = req;
    @(negedge clk);
    start = 1'b1; perm_on_wr = md; addr_gen = qp;
    blk_len = AW'(k); coef_lin = AW'(f1); coef_sq = AW'(f2);
    @(negedge clk);
    start = 1'b0;
    first_wr = -1; done_cyc = -1; tcnt = 0; tbl_bad = 0;
    for (int cyc = 1; cyc <= k + 40; cyc++) begin
      if (dst_wr_en && first_wr < 0) first_wr = cyc;
      if (tbl_rd_en) begin
        if (qp || int'(tbl_addr) != tcnt) tbl_bad++;
        tcnt++;
      end
      if (done) begin
        done_cyc = cyc;
        break;
      end
      chk(busy == 1'b1, "R6", "busy during block", busy, 1);
      if (perturb && cyc == k / 2) begin
        // R7: restart attempt and settings change mid-block
        start = 1'b1; perm_on_wr = ~md; addr_gen = ~qp; blk_len = AW'(40);
        coef_lin = AW'(1); coef_sq = AW'(2);
      end
      if (perturb && cyc == k / 2 + 2) start = 1'b0;
      @(negedge clk);
    end
    chk(first_wr == 3, "R5", "first write cycle", first_wr, 3);
    chk(done_cyc == k + 3, "R6", "done cycle", done_cyc, k + 3);
    chk(busy == 1'b0, "R6", "busy low with done", busy, 0);
    chk(exp_addr.size() == 0, "R5", "writes left over", exp_addr.size(), 0);
    if (qp) chk(tbl_bad == 0, "R4", "table touched in generator mode", tbl_bad, 0);
    else begin
      chk(tbl_bad == 0, "R3", "table address order", tbl_bad, 0);
      chk(tcnt == k, "R3", "table read count", tcnt, k);
    end
    if (perturb) chk(done_cyc == k + 3, "R7", "block unaffected by mid-run start", done_cyc, k + 3);
    start = 1'b0;
    @(negedge clk);
    chk(done == 1'b0, "R6", "done single cycle", done, 0);
    exp_addr.delete();
    exp_data.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R8: reset state
    chk(busy == 0, "R8", "busy in reset", busy, 0);
    chk(done == 0, "R8", "done in reset", done, 0);
    chk({tbl_rd_en, src_rd_en, dst_wr_en} == 3'b000, "R8", "enables in reset",
        {tbl_rd_en, src_rd_en, dst_wr_en}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk({tbl_rd_en, src_rd_en, dst_wr_en, busy} == 4'b0000, "R8", "idle after reset",
        {tbl_rd_en, src_rd_en, dst_wr_en, busy}, 0);

    run_block(1'b0, 1'b0, 40, 0, 0, 1'b0, 1, "R1");     // permute on read, table, smallest K
    run_block(1'b1, 1'b0, 40, 0, 0, 1'b0, 2, "R2");     // permute on write, table
    run_block(1'b0, 1'b1, 40, 3, 10, 1'b0, 3, "R4");    // generator, smallest K
    run_block(1'b1, 1'b1, 1008, 55, 84, 1'b0, 4, "R4"); // generator, many wraps
    run_block(1'b0, 1'b1, 512, 31, 64, 1'b1, 5, "R7");  // mid-run disturbance
    run_block(1'b1, 1'b0, 200, 0, 0, 1'b1, 6, "R7");    // mid-run disturbance, table

    repeat (4) @(negedge clk);
    chk({tbl_rd_en, src_rd_en, dst_wr_en, busy} == 4'b0000, "R8", "idle at end",
        {tbl_rd_en, src_rd_en, dst_wr_en, busy}, 0);
    summary();
  end

endmodule